// File: doc/BRIEF.md
# Daisy-Chain Serial Configuration Forwarder

This block is the serial configuration front end of one device in a chain of programmable devices. All devices in the chain share one configuration clock. Each device takes a serial stream on its input pin and passes a copy to the next device on its output pin. While the block waits for a configuration header, it relays every input bit to the output one clock later. It searches for a fixed 8-bit start pattern in a sliding window. The header is the start pattern followed by a 24-bit total length. Every device in the chain receives the same header.

After the header, the device takes in its own configuration frames. Each frame goes to a local frame store as one word. During this phase the output is held high, so devices further down the chain never see a start pattern. Once the last frame is stored, the block becomes a pass-through again. It relays bits until its bit counter, which started at the first bit of the start pattern, equals the length field. Then it raises a done flag and ignores further input. A length too short to hold the header plus this device's frames raises an error flag instead.

Top module: `chain_cfg_fwd`

## Requirements
- R1: A synchronous active-high reset returns the block to the start-pattern search and clears all counters. After the reset edge, `dout` is 1 and `done`, `err` and `frm_we` are 0.
- R2: During the search and while the length field arrives, every bit sampled from `din` on a rising clock edge appears on `dout` after that same edge, a delay of one cycle.
- R3: The start pattern is 8'hF2, received MSB first. It is found in a sliding 8-bit window (cleared by reset) at any bit alignment, and the first match ends the search.
- R4: The length field is 24 bits, sent MSB first, and follows the start pattern directly. It gives the total number of bits counted from the first bit of the start pattern.
- R5: From the bit after the length field until the last bit of the device's own frames, `dout` is 1.
- R6: Own-frame bits are packed MSB first into words of FRAME_W bits. After the edge that samples a word's last bit, `frm_we` is 1 for exactly one cycle, with `frm_data` holding the word and `frm_addr` holding the frame index (0, 1, 2, ...).
- R7: After the last own frame, each input bit is relayed to `dout` with a one-cycle delay, up to and including the bit at which the count equals the length.
- R8: `done` rises after the edge that samples the bit making the count equal the length, and stays high until reset. From the next edge on, `dout` is 1 and all input, including a new start pattern, is ignored.
- R9: If the length is less than 8 + 24 + NUM_FRAMES*FRAME_W, `err` rises after the edge that samples the last length bit and stays high. No frame is written, `done` stays 0 and `dout` stays 1.
- R10: A length exactly equal to that minimum forwards nothing. `done` rises after the edge that samples the last own-frame bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; all sampling and driving happen on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial configuration input from upstream |
| dout | output | 1 | Serial output to the next device in the chain |
| frm_we | output | 1 | One-cycle write strobe for the frame store |
| frm_addr | output | AW | Index of the frame being written |
| frm_data | output | FRAME_W | Assembled frame word, first received bit in the MSB |
| done | output | 1 | Length count reached |
| err | output | 1 | Length field too short for header plus own frames |

## Verification
The bench sweeps length values from the exact minimum up to many bits of pass-through. For each length, it varies how many idle bits come before the start pattern. The minimum length separates the direct jump to done (R10) from the pass-through phase, and each larger length tests where forwarding ends. One prefix contains near-miss patterns such as 8'hF3, which tests that the sliding search matches only the true pattern. Lengths just below the minimum and far below it must raise the error flag with no frame writes. A copy of the start pattern placed after the end of the stream must not restart the block.

// File: rtl/cfgfwd_pkg.sv
package cfgfwd_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_LEN,
        ST_OWN,
        ST_FWD,
        ST_HALT
    } phase_e;

endpackage

// File: rtl/cfgfwd_sieve.sv
module cfgfwd_sieve #(
    parameter int             W       = 8,
    parameter logic [W-1:0]   PATTERN = 8'hF2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic din,
    output logic hit
);
    logic [W-1:0] win_d, win_q;
    logic [W-1:0] shifted;

    assign shifted = {win_q[W-2:0], din};
    assign hit     = en && (shifted == PATTERN);

    always_comb begin
        win_d = win_q;
        if (rst)     win_d = '0;
        else if (en) win_d = shifted;
    end

    always_ff @(posedge clk) begin
        win_q <= win_d;
    end
endmodule

// File: rtl/cfgfwd_pack.sv
module cfgfwd_pack #(
    parameter int FRAME_W    = 64,
    parameter int NUM_FRAMES = 4,
    parameter int AW         = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               din,
    output logic               last,
    output logic               we,
    output logic [AW-1:0]      addr,
    output logic [FRAME_W-1:0] data
);
    localparam int BW = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;

    typedef struct packed {
        logic [FRAME_W-1:0] sh;
        logic [BW-1:0]      bitc;
        logic [AW-1:0]      frm;
        logic               we;
        logic [AW-1:0]      addr;
        logic [FRAME_W-1:0] data;
    } pack_t;

    pack_t p_d, p_q;
    logic  word_end;

    assign word_end = en && (p_q.bitc == BW'(FRAME_W - 1));
    assign last     = word_end && (p_q.frm == AW'(NUM_FRAMES - 1));

    always_comb begin
        p_d    = p_q;
        p_d.we = 1'b0;
        if (en) begin
            p_d.sh = {p_q.sh[FRAME_W-2:0], din};
            if (word_end) begin
                p_d.we   = 1'b1;
                p_d.data = {p_q.sh[FRAME_W-2:0], din};
                p_d.addr = p_q.frm;
                p_d.frm  = p_q.frm + 1'b1;
                p_d.bitc = '0;
            end else begin
                p_d.bitc = p_q.bitc + 1'b1;
            end
        end
        if (rst) begin
            p_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        p_q <= p_d;
    end

    assign we   = p_q.we;
    assign addr = p_q.addr;
    assign data = p_q.data;
endmodule

// File: rtl/chain_cfg_fwd.sv
module chain_cfg_fwd
    import cfgfwd_pkg::*;
#(
    parameter int               PRE_W      = 8,
    parameter logic [PRE_W-1:0] PREAMBLE   = 8'hF2,
    parameter int               LEN_W      = 24,
    parameter int               FRAME_W    = 64,
    parameter int               NUM_FRAMES = 4,
    localparam int              AW         = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               din,
    output logic               dout,
    output logic               frm_we,
    output logic [AW-1:0]      frm_addr,
    output logic [FRAME_W-1:0] frm_data,
    output logic               done,
    output logic               err
);
    localparam int               LC_W    = $clog2(LEN_W);
    localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(PRE_W + LEN_W + NUM_FRAMES * FRAME_W);

    typedef struct packed {
        phase_e             st;
        logic [LEN_W-1:0]   cnt;
        logic [LEN_W-1:0]   len;
        logic [LC_W-1:0]    lcnt;
        logic               dout;
        logic               done;
        logic               err;
    } ctl_t;

    ctl_t             c_d, c_q;
    logic             pre_hit;
    logic             own_last;
    logic [LEN_W-1:0] cnt_inc;
    logic [LEN_W-1:0] len_shift;

    cfgfwd_sieve #(
        .W       (PRE_W),
        .PATTERN (PREAMBLE)
    ) u_sieve (
        .clk (clk),
        .rst (rst),
        .en  (c_q.st == ST_HUNT),
        .din (din),
        .hit (pre_hit)
    );

    cfgfwd_pack #(
        .FRAME_W    (FRAME_W),
        .NUM_FRAMES (NUM_FRAMES),
        .AW         (AW)
    ) u_pack (
        .clk  (clk),
        .rst  (rst),
        .en   (c_q.st == ST_OWN),
        .din  (din),
        .last (own_last),
        .we   (frm_we),
        .addr (frm_addr),
        .data (frm_data)
    );

    assign cnt_inc   = c_q.cnt + 1'b1;
    assign len_shift = {c_q.len[LEN_W-2:0], din};

    always_comb begin
        c_d      = c_q;
        c_d.dout = 1'b1;
        unique case (c_q.st)
            ST_HUNT: begin
                c_d.dout = din;
                if (pre_hit) begin
                    c_d.st   = ST_LEN;
                    c_d.cnt  = LEN_W'(PRE_W);
                    c_d.lcnt = '0;
                end
            end
            ST_LEN: begin
                c_d.dout = din;
                c_d.cnt  = cnt_inc;
                c_d.len  = len_shift;
                c_d.lcnt = c_q.lcnt + 1'b1;
                if (c_q.lcnt == LC_W'(LEN_W - 1)) begin
                    if (len_shift < MIN_LEN) begin
                        c_d.err = 1'b1;
                        c_d.st  = ST_HALT;
                    end else begin
                        c_d.st  = ST_OWN;
                    end
                end
            end
            ST_OWN: begin
                c_d.cnt = cnt_inc;
                if (own_last) begin
                    if (cnt_inc == c_q.len) begin
                        c_d.done = 1'b1;
                        c_d.st   = ST_HALT;
                    end else begin
                        c_d.st   = ST_FWD;
                    end
                end
            end
            ST_FWD: begin
                c_d.dout = din;
                c_d.cnt  = cnt_inc;
                if (cnt_inc == c_q.len) begin
                    c_d.done = 1'b1;
                    c_d.st   = ST_HALT;
                end
            end
            ST_HALT: begin
                c_d.dout = 1'b1;
            end
            default: begin
                c_d.st = ST_HUNT;
            end
        endcase
        if (rst) begin
            c_d.st   = ST_HUNT;
            c_d.cnt  = '0;
            c_d.len  = '0;
            c_d.lcnt = '0;
            c_d.dout = 1'b1;
            c_d.done = 1'b0;
            c_d.err  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        c_q <= c_d;
    end

    assign dout = c_q.dout;
    assign done = c_q.done;
    assign err  = c_q.err;
endmodule

// File: rtl/chain_cfg_fwd_chk.sv
module chain_cfg_fwd_chk #(
    parameter int NUM_FRAMES = 4,
    parameter int AW         = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          dout,
    input logic          frm_we,
    input logic [AW-1:0] frm_addr,
    input logic          done,
    input logic          err
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (dout && !done && !err && !frm_we));

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> dout);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R9
    err_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> (!frm_we && !done));

    // R6
    we_single_chk: assert property (@(posedge clk) disable iff (rst)
        frm_we |=> !frm_we);

    // R6
    addr_range_chk: assert property (@(posedge clk) disable iff (rst)
        frm_we |-> (frm_addr <= AW'(NUM_FRAMES - 1)));
endmodule

bind chain_cfg_fwd chain_cfg_fwd_chk #(
    .NUM_FRAMES (NUM_FRAMES),
    .AW         (AW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .dout     (dout),
    .frm_we   (frm_we),
    .frm_addr (frm_addr),
    .done     (done),
    .err      (err)
);

// File: tb/chain_cfg_fwd_test.sv
module chain_cfg_fwd_test;
    localparam int FW   = 8;
    localparam int NF   = 3;
    localparam int LW   = 24;
    localparam int MINL = 8 + LW + NF * FW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          din = 1'b1;
    logic          dout;
    logic          frm_we;
    logic [1:0]    frm_addr;
    logic [FW-1:0] frm_data;
    logic          done;
    logic          err;

    int checks = 0;
    int fails  = 0;
    bit b[1024];
    int nb;

    always #4 clk = ~clk;

    chain_cfg_fwd #(
        .FRAME_W    (FW),
        .NUM_FRAMES (NF)
    ) uut (
        .clk      (clk),
        .rst      (rst),
        .din      (din),
        .dout     (dout),
        .frm_we   (frm_we),
        .frm_addr (frm_addr),
        .frm_data (frm_data),
        .done     (done),
        .err      (err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit pay(int i, int s);
        return ((i * 13 + s * 7) % 11) < 5;
    endfunction

    task automatic run(input logic [31:0] pre, input int npre, input int len, input int seed);
        int pend, w, hdr_last, own_start, own_end, last, npay;
        bit errc;
        logic [7:0] pat;
        logic [FW-1:0] word;
        pat = 8'hF2;
        nb = 0;
        for (int k = npre - 1; k >= 0; k--) begin b[nb] = pre[k]; nb++; end
        for (int k = 7; k >= 0; k--) begin b[nb] = pat[k]; nb++; end
        for (int k = LW - 1; k >= 0; k--) begin b[nb] = len[k]; nb++; end
        npay = (len >= MINL) ? len - 8 - LW : NF * FW;
        for (int k = 0; k < npay; k++) begin b[nb] = pay(k, seed); nb++; end
        for (int k = 7; k >= 0; k--) begin b[nb] = pat[k]; nb++; end
        for (int k = 0; k < 4; k++) begin b[nb] = k[0]; nb++; end

        w = 0; pend = -1;
        for (int i = 0; i < nb; i++) begin
            w = ((w << 1) | int'(b[i])) & 255;
            if (w == 8'hF2 && pend < 0) pend = i;
        end
        chk(pend == npre + 7, "R3", "bench pattern position", pend, npre + 7);

        errc      = (len < MINL);
        hdr_last  = pend + LW;
        own_start = hdr_last + 1;
        own_end   = own_start + NF * FW;
        last      = pend - 7 + len - 1;

        @(negedge clk);
        rst = 1'b1; din = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(dout == 1'b1, "R1", "dout after reset", dout, 1);
        chk({done, err, frm_we} == 3'b000, "R1", "flags after reset", {done, err, frm_we}, 0);
        rst = 1'b0;

        for (int i = 0; i < nb; i++) begin
            bit ed, ewe;
            string rq;
            din = b[i];
            @(posedge clk);
            @(negedge clk);
            if (i <= hdr_last)     begin ed = b[i]; rq = "R2"; end
            else if (errc)         begin ed = 1'b1; rq = "R9"; end
            else if (i < own_end)  begin ed = 1'b1; rq = "R5"; end
            else if (i <= last)    begin ed = b[i]; rq = "R7"; end
            else                   begin ed = 1'b1; rq = "R8"; end
            chk(dout == ed, rq, $sformatf("dout bit %0d", i), dout, ed);
            chk(done == (!errc && i >= last), (len == MINL) ? "R10" : "R4/R8",
                $sformatf("done bit %0d len %0d", i, len), done, (!errc && i >= last));
            chk(err == (errc && i >= hdr_last), "R9",
                $sformatf("err bit %0d len %0d", i, len), err, (errc && i >= hdr_last));
            ewe = !errc && i >= own_start && i < own_end && ((i - own_start) % FW == FW - 1);
            chk(frm_we == ewe, "R6", $sformatf("frm_we bit %0d", i), frm_we, ewe);
            if (ewe) begin
                int fk;
                fk = (i - own_start) / FW;
                for (int j = 0; j < FW; j++) word[FW-1-j] = b[own_start + fk * FW + j];
                chk(frm_addr == fk[1:0], "R6", "frame address", frm_addr, fk);
                chk(frm_data == word, "R6", "frame word", frm_data, word);
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        for (int e = 0; e <= 12; e++) run(32'hFFFF_FFFF, e % 5, MINL + e * 3, e);
        run(32'b1_1110_0111_1101, 13, MINL + 40, 20);
        run(32'h0, 0, MINL + 150, 21);
        run(32'hFFFF_FFFF, 2, MINL - 1, 3);
        run(32'hFFFF_FFFF, 0, 20, 4);
        run(32'hFFFF_FFFF, 6, MINL - FW, 5);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule